// File: doc/BRIEF.md
# Cascaded Match-Flag Priority Node

This block is the per-device piece of a vertical cascade of match devices. Each device runs compares in its own match array (not part of this block), and the node holds the outcome: a local match flag, a local multiple-match flag and the address of the local hit. The node takes the combined flags of all higher-priority devices on `match_in` and `multi_in` and passes the combined flags, with its own result added, to the next device down through `match_out` and `multi_out`. From these it decides whether it alone owns the shared result bus.

A compare is framed by an active-low enable strobe. While the strobe is low the held flags keep their old values, so a long chain can stay resolved from the previous compare. The new result appears only after the strobe returns high. The flags then persist through later non-compare cycles. A release pulse hands the bus to other traffic, and a recall pulse brings the stored match address back without a new compare, so the chain does not have to resolve priority again. The status copies of the flags describe only this device. A configuration input marks the lowest-priority device, which is the only one that reports cascade-wide flags.

Top module: `match_chain_node`

## Requirements
- R1: While `rst_n` is low and at the first sample after it: `stat_match`, `stat_multi` and `bus_drive` are 0, and `match_out` equals `match_in`.
- R2: During a compare (`en_n` low with `cmp` high) the status flags do not change. At the first rising clock edge where `en_n` is high after being low, the flags take the last values sampled while the strobe was low: `stat_match` = `hit` and `stat_multi` = `hit & hit_multi`. `stat_multi` is never set without `stat_match`.
- R3: A strobe with `cmp` low, and any cycle with the strobe high, leaves the flags and the stored address unchanged.
- R4: `match_out` = `match_in | stat_match`, combinationally.
- R5: `multi_out` = `multi_in | stat_multi | (match_in & stat_match)`, combinationally.
- R6: `bus_drive` is 1 only when `stat_match` is 1, `match_in` is 0, `oe_n` is 0 and the node is presenting its match address. A committed compare sets the presenting state.
- R7: `bus_addr` = {`page`, stored hit address}, with `page` in the top PAGE_W bits and the address in the low ADDR_W bits.
- R8: A `bus_release` pulse clears the presenting state, so `bus_drive` becomes 0. A later `recall` pulse sets it again, with the same stored address and flags and no new compare. A commit has priority over a recall, and a recall has priority over a release.
- R9: `stat_match` and `stat_multi` do not depend on `match_in` or `multi_in`.
- R10: `sys_match` = `is_last & match_out` and `sys_multi` = `is_last & multi_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_n | input | 1 | Active-low cycle strobe |
| cmp | input | 1 | The current strobe is a compare |
| hit | input | 1 | Local array match result |
| hit_multi | input | 1 | Local array found more than one match |
| hit_addr | input | ADDR_W | Address of the highest-priority local hit |
| recall | input | 1 | Present the stored match address again |
| bus_release | input | 1 | The bus now carries another address |
| oe_n | input | 1 | Active-low output enable of the result bus |
| is_last | input | 1 | Configuration: lowest-priority device in the cascade |
| page | input | PAGE_W | Device page address |
| match_in | input | 1 | Match flag from higher-priority devices |
| multi_in | input | 1 | Multiple-match flag from higher-priority devices |
| match_out | output | 1 | Match flag to lower-priority devices |
| multi_out | output | 1 | Multiple-match flag to lower-priority devices |
| stat_match | output | 1 | Local match flag (status copy) |
| stat_multi | output | 1 | Local multiple-match flag (status copy) |
| bus_drive | output | 1 | This device drives the result bus |
| bus_addr | output | PAGE_W+ADDR_W | Page and match address for the bus |
| sys_match | output | 1 | Cascade-wide match flag, lowest device only |
| sys_multi | output | 1 | Cascade-wide multiple-match flag, lowest device only |

## Verification
The bench holds the strobe low for one to four cycles and changes the hit inputs on every cycle. A node that let the flags follow during the strobe, or that kept the first sample instead of the last, shows a mismatch before or at the rising edge. Non-compare strobes carry random hit values, which catches a node that treats every strobe as a compare. Release, recall and same-cycle collisions between them check that the address comes back without a compare and that the priority order holds. The chain inputs are swept randomly to catch a device that drives while a higher device matches, a missing two-device multiple-match term, or status flags that mix in the chain input.

// File: rtl/match_chain_node.sv
module match_chain_node #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 4,
  localparam int BUS_W = PAGE_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic              cmp,
  input  logic              hit,
  input  logic              hit_multi,
  input  logic [ADDR_W-1:0] hit_addr,
  input  logic              recall,
  input  logic              bus_release,
  input  logic              oe_n,
  input  logic              is_last,
  input  logic [PAGE_W-1:0] page,
  input  logic              match_in,
  input  logic              multi_in,
  output logic              match_out,
  output logic              multi_out,
  output logic              stat_match,
  output logic              stat_multi,
  output logic              bus_drive,
  output logic [BUS_W-1:0]  bus_addr,
  output logic              sys_match,
  output logic              sys_multi
);

  logic              en_q;
  logic              pend_vld;
  logic              pend_hit;
  logic              pend_multi;
  logic [ADDR_W-1:0] pend_addr;
  logic              loc_match;
  logic              loc_multi;
  logic [ADDR_W-1:0] loc_addr;
  logic              showing;
  logic              commit;

  assign commit = en_n && !en_q && pend_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q       <= 1'b1;
      pend_vld   <= 1'b0;
      pend_hit   <= 1'b0;
      pend_multi <= 1'b0;
      pend_addr  <= '0;
    end else begin
      en_q <= en_n;
      if (!en_n && cmp) begin
        pend_vld   <= 1'b1;
        pend_hit   <= hit;
        pend_multi <= hit & hit_multi;
        pend_addr  <= hit_addr;
      end else if (commit) begin
        pend_vld <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loc_match <= 1'b0;
      loc_multi <= 1'b0;
      loc_addr  <= '0;
      showing   <= 1'b0;
    end else begin
      if (commit) begin
        loc_match <= pend_hit;
        loc_multi <= pend_multi;
        loc_addr  <= pend_addr;
      end
      if (commit || recall)
        showing <= 1'b1;
      else if (bus_release)
        showing <= 1'b0;
    end
  end

  assign stat_match = loc_match;
  assign stat_multi = loc_multi;
  assign match_out  = match_in | loc_match;
  assign multi_out  = multi_in | loc_multi | (match_in & loc_match);
  assign bus_drive  = loc_match & ~match_in & ~oe_n & showing;
  assign bus_addr   = {page, loc_addr};
  assign sys_match  = is_last & match_out;
  assign sys_multi  = is_last & multi_out;

endmodule

module match_chain_node_chk #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 4
) (
  input logic clk,
  input logic rst_n,
  input logic en_n,
  input logic oe_n,
  input logic is_last,
  input logic match_in,
  input logic multi_in,
  input logic match_out,
  input logic multi_out,
  input logic stat_match,
  input logic stat_multi,
  input logic bus_drive,
  input logic sys_match,
  input logic sys_multi
);

  p_hold_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_n |=> ($stable(stat_match) && $stable(stat_multi)));

  p_multi_has_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stat_multi |-> stat_match);

  p_hold_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_n && $past(en_n)) |=> ($stable(stat_match) && $stable(stat_multi)));

  p_chain_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (match_in || stat_match) |-> match_out);

  p_chain_multi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_in && stat_match) |-> multi_out);

  p_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> (stat_match && !match_in && !oe_n));

  p_last_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !is_last |-> (!sys_match && !sys_multi));

  p_last_mirror_r10: assert property (@(posedge clk) disable iff (!rst_n)
    is_last |-> (sys_match == match_out && sys_multi == multi_out));

endmodule

bind match_chain_node match_chain_node_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_n(en_n), .oe_n(oe_n), .is_last(is_last),
  .match_in(match_in), .multi_in(multi_in), .match_out(match_out),
  .multi_out(multi_out), .stat_match(stat_match), .stat_multi(stat_multi),
  .bus_drive(bus_drive), .sys_match(sys_match), .sys_multi(sys_multi)
);

// File: tb/match_chain_node_bench.sv
module match_chain_node_bench;
  localparam int AW = 13;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rst_n, en_n, cmp, hit, hit_multi, recall, bus_release, oe_n, is_last;
  logic match_in, multi_in;
  logic [AW-1:0] hit_addr;
  logic [PW-1:0] page;
  logic match_out, multi_out, stat_match, stat_multi, bus_drive, sys_match, sys_multi;
  logic [PW+AW-1:0] bus_addr;

  int tests = 0;
  int fails = 0;
  logic e_m, e_mm, e_sel;
  logic [AW-1:0] e_addr;

  always #5 clk = ~clk;

  match_chain_node #(.ADDR_W(AW), .PAGE_W(PW)) u_match_chain_node (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .cmp(cmp), .hit(hit),
    .hit_multi(hit_multi), .hit_addr(hit_addr), .recall(recall),
    .bus_release(bus_release), .oe_n(oe_n), .is_last(is_last), .page(page),
    .match_in(match_in), .multi_in(multi_in), .match_out(match_out),
    .multi_out(multi_out), .stat_match(stat_match), .stat_multi(stat_multi),
    .bus_drive(bus_drive), .bus_addr(bus_addr), .sys_match(sys_match),
    .sys_multi(sys_multi)
  );

  function automatic logic f_mout(logic mi, logic m);
    return mi | m;
  endfunction
  function automatic logic f_multi(logic mi, logic ui, logic m, logic mm);
    return ui | mm | (mi & m);
  endfunction
  function automatic logic f_drive(logic m, logic mi, logic oen, logic sel);
    return m & !mi & !oen & sel;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic em, eu, ed;
    em = f_mout(match_in, e_m);
    eu = f_multi(match_in, multi_in, e_m, e_mm);
    ed = f_drive(e_m, match_in, oe_n, e_sel);
    chk(stat_match == e_m && stat_multi == e_mm, {tag, " R2 stat"}, {stat_match, stat_multi}, {e_m, e_mm});
    chk(match_out == em, {tag, " R4 match_out"}, match_out, em);
    chk(multi_out == eu, {tag, " R5 multi_out"}, multi_out, eu);
    chk(bus_drive == ed, {tag, " R6 bus_drive"}, bus_drive, ed);
    chk(bus_addr == {page, e_addr}, {tag, " R7 bus_addr"}, bus_addr, {page, e_addr});
    chk(sys_match == (is_last & em) && sys_multi == (is_last & eu), {tag, " R10 sys"},
        {sys_match, sys_multi}, {is_last & em, is_last & eu});
  endtask

  task automatic do_cmp(input int n);
    logic h, hm;
    logic [AW-1:0] a;
    for (int i = 0; i < n; i++) begin
      h = 1'($urandom); hm = 1'($urandom); a = AW'($urandom);
      en_n = 1'b0; cmp = 1'b1; hit = h; hit_multi = hm; hit_addr = a;
      step();
      chk(stat_match == e_m && stat_multi == e_mm, "R2 hold while strobe low",
          {stat_match, stat_multi}, {e_m, e_mm});
    end
    en_n = 1'b1; cmp = 1'b0; hit = 1'($urandom); hit_multi = 1'($urandom); hit_addr = AW'($urandom);
    step();
    e_m = h; e_mm = h & hm; e_addr = a; e_sel = 1'b1;
    check_all("after compare");
  endtask

  task automatic do_other(input int n);
    for (int i = 0; i < n; i++) begin
      en_n = 1'b0; cmp = 1'b0; hit = 1'($urandom); hit_multi = 1'($urandom); hit_addr = AW'($urandom);
      step();
    end
    en_n = 1'b1;
    step();
    check_all("R3 non-compare strobe");
  endtask

  task automatic pulse(input bit rel, input bit rec);
    bus_release = rel; recall = rec;
    step();
    bus_release = 1'b0; recall = 1'b0;
    if (rec) e_sel = 1'b1;
    else if (rel) e_sel = 1'b0;
    check_all("R8 release/recall");
  endtask

  task automatic sweep_chain(input int n);
    for (int i = 0; i < n; i++) begin
      logic sm, su;
      sm = stat_match; su = stat_multi;
      match_in = 1'($urandom); multi_in = 1'($urandom); oe_n = 1'($urandom); is_last = 1'($urandom);
      #1;
      chk(stat_match == sm && stat_multi == su, "R9 status ignores chain inputs",
          {stat_match, stat_multi}, {sm, su});
      check_all("chain sweep");
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; en_n = 1'b1; cmp = 1'b0; hit = 1'b1; hit_multi = 1'b1; hit_addr = '1;
    recall = 1'b0; bus_release = 1'b0; oe_n = 1'b0; is_last = 1'b1; page = 4'hA;
    match_in = 1'b0; multi_in = 1'b0;
    e_m = 1'b0; e_mm = 1'b0; e_sel = 1'b0; e_addr = '0;
    repeat (3) step();
    chk(stat_match == 0 && stat_multi == 0 && bus_drive == 0, "R1 reset flags",
        {stat_match, stat_multi, bus_drive}, 0);
    chk(match_out == match_in, "R1 reset match_out", match_out, match_in);
    rst_n = 1'b1;
    step();
    check_all("R1 after reset");

    // directed: local hit, no higher match -> owner drives
    en_n = 1'b0; cmp = 1'b1; hit = 1'b0; hit_multi = 1'b0; hit_addr = 13'h0123;
    step();
    hit = 1'b1; hit_multi = 1'b1; hit_addr = 13'h1ABC;
    step();
    chk(stat_match == 1'b0, "R2 not latched while low", stat_match, 0);
    en_n = 1'b1; cmp = 1'b0;
    step();
    e_m = 1'b1; e_mm = 1'b1; e_addr = 13'h1ABC; e_sel = 1'b1;
    match_in = 1'b0; oe_n = 1'b0; #1;
    chk(bus_drive == 1'b1, "R6 owner drives", bus_drive, 1);
    chk(bus_addr == {4'hA, 13'h1ABC}, "R7 page and address", bus_addr, {4'hA, 13'h1ABC});
    match_in = 1'b1; #1;
    chk(bus_drive == 1'b0, "R6 higher device wins", bus_drive, 0);
    chk(multi_out == 1'b1, "R5 two devices match", multi_out, 1);
    match_in = 1'b0; #1;

    do_other(2);
    pulse(1'b1, 1'b0);
    chk(bus_drive == 1'b0, "R8 released", bus_drive, 0);
    do_other(1);
    pulse(1'b0, 1'b1);
    chk(bus_drive == 1'b1 && bus_addr[AW-1:0] == 13'h1ABC, "R8 recall restores", bus_addr, 13'h1ABC);
    pulse(1'b1, 1'b1);
    chk(bus_drive == 1'b1, "R8 recall over release", bus_drive, 1);

    // commit and release in the same cycle: commit wins
    bus_release = 1'b0;
    en_n = 1'b0; cmp = 1'b1; hit = 1'b1; hit_multi = 1'b0; hit_addr = 13'h0007;
    step();
    en_n = 1'b1; cmp = 1'b0; bus_release = 1'b1;
    step();
    bus_release = 1'b0;
    e_m = 1'b1; e_mm = 1'b0; e_addr = 13'h0007; e_sel = 1'b1;
    check_all("R8 commit over release");

    for (int k = 0; k < 300; k++) begin
      case ($urandom % 5)
        0, 1: do_cmp(1 + int'($urandom % 4));
        2: do_other(1 + int'($urandom % 3));
        3: pulse(1'($urandom), 1'($urandom));
        default: sweep_chain(4);
      endcase
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule